// File: doc/BRIEF.md
# SIMD Multiply-Accumulate Unit with Saturating Extraction

This block multiplies two 128-bit operand vectors lane by lane and adds the products into one 320-bit accumulator register. The accumulator has two views, picked by a mode input on each command. In byte mode it holds sixteen signed 20-bit lanes, and each lane takes the product of two signed 8-bit elements. In halfword mode it holds eight signed 40-bit lanes, and each lane takes the product of two signed 16-bit elements. The accumulator splits into an upper 160-bit half and a lower 160-bit half. Both views lie over the same storage, so changing the mode changes only how the stored bits are read.

Results leave the block through an extract command. The command shifts every lane right arithmetically by a 6-bit amount, clamps the value to the output element range and packs the elements into a 128-bit word. That word is registered and comes with a one-cycle valid strobe. A raw read port returns any 32-bit segment of the accumulator combinationally, with no shift and no clamping. A clear command zeroes the accumulator in one cycle.

Top module: `simd_mac_acc`

## Requirements
- R1: After reset the accumulator is all zero, `ext_valid` is 0 and `ext_data` is 0.
- R2: `cmd_clr` zeroes the whole accumulator at the next clock edge. When `cmd_mac` is asserted in the same cycle, the clear wins.
- R3: In byte mode (`mode16`=0), `cmd_mac` adds the signed product of `opa[8i+7:8i]` and `opb[8i+7:8i]` into lane i, which is accumulator bits [20i+19:20i], for i=0..15. The sum wraps modulo 2^20.
- R4: In halfword mode (`mode16`=1), `cmd_mac` adds the signed product of `opa[16j+15:16j]` and `opb[16j+15:16j]` into lane j, which is accumulator bits [40j+39:40j], for j=0..7. The sum wraps modulo 2^40.
- R5: A byte-mode extract shifts each 20-bit lane right arithmetically by `shamt` (0..63). It clamps the result to the range -128..127 and puts lane i in `ext_data[8i+7:8i]`.
- R6: A halfword-mode extract shifts each 40-bit lane right arithmetically by `shamt`. It clamps the result to the range -32768..32767 and puts lane j in `ext_data[16j+15:16j]`.
- R7: `ext_valid` is high for exactly the one cycle that follows a cycle with `cmd_ext`. `ext_data` changes only on an extract and holds its value otherwise.
- R8: `seg_data` shows accumulator bits [32k+31:32k] for `seg_sel`=k<10 and shows zero for k≥10, with no clock delay. Segments 0..4 form the lower half and segments 5..9 form the upper half.
- R9: In a cycle with neither `cmd_clr` nor `cmd_mac`, the accumulator keeps its value.
- R10: An extract issued in the same cycle as a clear or a multiply-accumulate works on the accumulator value from before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_clr | input | 1 | Zero the accumulator |
| cmd_mac | input | 1 | Multiply-accumulate opa by opb |
| cmd_ext | input | 1 | Shift, clamp and pack into ext_data |
| mode16 | input | 1 | 0: sixteen 20-bit lanes, 1: eight 40-bit lanes |
| opa | input | 128 | First operand vector |
| opb | input | 128 | Second operand vector |
| shamt | input | 6 | Right-shift amount for extract |
| seg_sel | input | 4 | Raw segment index |
| seg_data | output | 32 | Selected raw 32-bit segment |
| ext_data | output | 128 | Packed extract result |
| ext_valid | output | 1 | Strobe, one cycle after an extract command |

## Verification
The bound assertions check the following on every cycle: clear priority, the accumulator holding its value when idle, the accumulator staying unchanged on a multiply-accumulate with a zero operand, the timing of the valid strobe, and `ext_data` holding between extracts. The lane arithmetic cannot be written as a short property. This covers wrap at 2^20 and 2^40, sign-preserving shifts up to 63, clamping at both ends, lane ordering in the packed word, segment indexing, and extract reading the value from before the update. Only the bench's reference model shows these. It compares them after every clock under directed overflow runs, shift sweeps and pseudo-random operands.

// File: rtl/simd_mac_acc.sv
module simd_mac_acc #(
  parameter int VEC_W = 128,
  parameter int ACC_W = 320,
  parameter int SEG_W = 32,
  parameter int SH_W  = 6,
  localparam int NSEG  = ACC_W / SEG_W,
  localparam int SEL_W = $clog2(NSEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_clr,
  input  logic             cmd_mac,
  input  logic             cmd_ext,
  input  logic             mode16,
  input  logic [VEC_W-1:0] opa,
  input  logic [VEC_W-1:0] opb,
  input  logic [SH_W-1:0]  shamt,
  input  logic [SEL_W-1:0] seg_sel,
  output logic [SEG_W-1:0] seg_data,
  output logic [VEC_W-1:0] ext_data,
  output logic             ext_valid
);
  localparam int N8  = VEC_W / 8;
  localparam int N16 = VEC_W / 16;
  localparam int L8  = ACC_W / N8;
  localparam int L16 = ACC_W / N16;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum8, sum16;
  logic [VEC_W-1:0] pk8, pk16;
  logic [SEG_W-1:0] segs [NSEG];

  for (genvar i = 0; i < N8; i++) begin : g_b
    localparam logic signed [L8-1:0] HI = L8'(127);
    localparam logic signed [L8-1:0] LO = -L8'(128);
    logic signed [15:0]   prod;
    logic signed [L8-1:0] lane, shr;
    assign prod = $signed(opa[8*i +: 8]) * $signed(opb[8*i +: 8]);
    assign lane = acc[L8*i +: L8];
    assign sum8[L8*i +: L8] = lane + {{(L8-16){prod[15]}}, prod};
    assign shr  = lane >>> shamt;
    assign pk8[8*i +: 8] = (shr > HI) ? 8'h7f : (shr < LO) ? 8'h80 : shr[7:0];
  end

  for (genvar j = 0; j < N16; j++) begin : g_h
    localparam logic signed [L16-1:0] HI = L16'(32767);
    localparam logic signed [L16-1:0] LO = -L16'(32768);
    logic signed [31:0]    prod;
    logic signed [L16-1:0] lane, shr;
    assign prod = $signed(opa[16*j +: 16]) * $signed(opb[16*j +: 16]);
    assign lane = acc[L16*j +: L16];
    assign sum16[L16*j +: L16] = lane + {{(L16-32){prod[31]}}, prod};
    assign shr  = lane >>> shamt;
    assign pk16[16*j +: 16] = (shr > HI) ? 16'h7fff : (shr < LO) ? 16'h8000 : shr[15:0];
  end

  for (genvar k = 0; k < NSEG; k++) begin : g_s
    assign segs[k] = acc[SEG_W*k +: SEG_W];
  end

  assign seg_data = (int'(seg_sel) < NSEG) ? segs[seg_sel] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      ext_data  <= '0;
      ext_valid <= 1'b0;
    end else begin
      if (cmd_clr)      acc <= '0;
      else if (cmd_mac) acc <= mode16 ? sum16 : sum8;
      if (cmd_ext)      ext_data <= mode16 ? pk16 : pk8;
      ext_valid <= cmd_ext;
    end
  end
endmodule

// File: rtl/simd_mac_acc_chk.sv
module simd_mac_acc_chk #(
  parameter int VEC_W = 128,
  parameter int ACC_W = 320
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_clr,
  input logic             cmd_mac,
  input logic             cmd_ext,
  input logic [VEC_W-1:0] opa,
  input logic [ACC_W-1:0] acc,
  input logic [VEC_W-1:0] ext_data,
  input logic             ext_valid
);
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n) cmd_clr |=> acc == '0); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!cmd_clr && !cmd_mac) |=> $stable(acc)); // R9
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n) (cmd_mac && !cmd_clr && opa == '0) |=> $stable(acc)); // R3
  AST_VALID_AFTER_EXT: assert property (@(posedge clk) disable iff (!rst_n) cmd_ext |=> ext_valid); // R7
  AST_VALID_ONLY_EXT: assert property (@(posedge clk) disable iff (!rst_n) !cmd_ext |=> !ext_valid); // R7
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n) !cmd_ext |=> $stable(ext_data)); // R7
endmodule

bind simd_mac_acc simd_mac_acc_chk #(.VEC_W(VEC_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_clr(cmd_clr), .cmd_mac(cmd_mac), .cmd_ext(cmd_ext),
  .opa(opa), .acc(acc), .ext_data(ext_data), .ext_valid(ext_valid)
);

// File: tb/sim_simd_mac_acc.sv
module sim_simd_mac_acc;
  logic clk = 0, rst_n = 0;
  logic cmd_clr = 0, cmd_mac = 0, cmd_ext = 0, mode16 = 0;
  logic [127:0] opa = '0, opb = '0;
  logic [5:0] shamt = '0;
  logic [3:0] seg_sel = '0;
  logic [31:0] seg_data;
  logic [127:0] ext_data;
  logic ext_valid;

  int compared = 0, mismatched = 0;
  logic [319:0] m_acc = '0;
  logic [127:0] m_ext = '0;
  logic m_v = 0;

  always #2 clk = ~clk;

  simd_mac_acc u0 (.*);

  function automatic logic [319:0] ref_mac(logic [319:0] a, bit h, logic [127:0] x, logic [127:0] y);
    logic [319:0] r = a;
    if (!h) for (int i = 0; i < 16; i++) begin
      logic signed [19:0] l = a[20*i +: 20];
      logic signed [7:0] p = x[8*i +: 8], q = y[8*i +: 8];
      longint s = longint'(l) + longint'(p) * longint'(q);
      r[20*i +: 20] = 20'(s);
    end else for (int j = 0; j < 8; j++) begin
      logic signed [39:0] l = a[40*j +: 40];
      logic signed [15:0] p = x[16*j +: 16], q = y[16*j +: 16];
      longint s = longint'(l) + longint'(p) * longint'(q);
      r[40*j +: 40] = 40'(s);
    end
    return r;
  endfunction

  function automatic logic [127:0] ref_ext(logic [319:0] a, bit h, int sh);
    logic [127:0] r = '0;
    if (!h) for (int i = 0; i < 16; i++) begin
      logic signed [19:0] l = a[20*i +: 20];
      longint v = longint'(l) >>> sh;
      if (v > 127) v = 127;
      if (v < -128) v = -128;
      r[8*i +: 8] = 8'(v);
    end else for (int j = 0; j < 8; j++) begin
      logic signed [39:0] l = a[40*j +: 40];
      longint v = longint'(l) >>> sh;
      if (v > 32767) v = 32767;
      if (v < -32768) v = -32768;
      r[16*j +: 16] = 16'(v);
    end
    return r;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(string tg, bit c, bit m, bit e, bit h, logic [127:0] a, logic [127:0] b, int sh, int sel);
    logic [31:0] sexp;
    @(negedge clk);
    cmd_clr = c; cmd_mac = m; cmd_ext = e; mode16 = h;
    opa = a; opb = b; shamt = 6'(sh); seg_sel = 4'(sel);
    if (e) m_ext = ref_ext(m_acc, h, sh);   // R10: pre-update value
    m_v = e;
    if (c) m_acc = '0;
    else if (m) m_acc = ref_mac(m_acc, h, a, b);
    @(posedge clk); #1;
    chk({tg, " R7 valid"}, 128'(ext_valid), 128'(m_v));
    chk({tg, " ext_data"}, ext_data, m_ext);
    sexp = (sel < 10) ? m_acc[32*sel +: 32] : 32'h0;
    chk({tg, " R8 seg"}, 128'(seg_data), 128'(sexp));
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #800000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ext_data", ext_data, '0);
    chk("R1 ext_valid", 128'(ext_valid), '0);
    @(negedge clk); rst_n = 1;
    for (int k = 0; k < 16; k++) step("R1 R8 reset segs", 0, 0, 0, 0, '0, '0, 0, k);

    // R3 byte lanes, distinct lane values
    begin
      logic [127:0] a, b;
      for (int i = 0; i < 16; i++) begin a[8*i +: 8] = 8'(i * 17 - 100); b[8*i +: 8] = 8'(3 - i * 9); end
      for (int n = 0; n < 4; n++) step("R3 mac8", 0, 1, 0, 0, a, b, 0, n);
      foreach (int_sh[s]) ;
    end
    for (int s = 0; s < 24; s++) step("R5 ext8 shift", 0, 0, 1, 0, '0, '0, s, s % 16);
    step("R5 ext8 sh63", 0, 0, 1, 0, '0, '0, 63, 2);

    // R3 wrap at 2^20 and R5 clamping both directions
    step("R2 clr", 1, 0, 0, 0, '0, '0, 0, 0);
    for (int n = 0; n < 40; n++)
      step("R3 wrap8", 0, 1, (n % 5) == 0, 0, {16{8'h7f}}, {8{16'h807f}}, n % 21, n % 10);
    step("R5 ext8 wrapped", 0, 0, 1, 0, '0, '0, 0, 9);

    // R2 clear wins over mac; R10 extract sees pre-clear value
    step("R2 R10 clr+mac+ext", 1, 1, 1, 0, {16{8'h7f}}, {16{8'h7f}}, 4, 0);
    step("R2 zero after", 0, 0, 1, 0, '0, '0, 0, 3);

    // R4 halfword lanes and R6 clamping, wrap at 2^40
    for (int n = 0; n < 600; n++)
      step("R4 mac16 wrap", 0, 1, (n % 50) == 0, 1, {8{16'h8000}}, {4{32'h8000_7fff}}, (n / 50) * 5, n % 10);
    for (int s = 0; s < 64; s += 3) step("R6 ext16 shift", 0, 0, 1, 1, '0, '0, s, s % 12);

    // R9 idle hold, R10 extract with mac same cycle
    for (int n = 0; n < 6; n++) step("R9 idle", 0, 0, 0, 1, rnd128(), rnd128(), 0, n);
    step("R2 clr16", 1, 0, 0, 1, '0, '0, 0, 0);
    for (int n = 0; n < 150; n++)
      step("R4 R6 R10 rand16", 0, $urandom_range(0, 3) != 0, $urandom_range(0, 1), 1,
           rnd128(), rnd128(), $urandom_range(0, 63), $urandom_range(0, 15));
    for (int n = 0; n < 150; n++)
      step("R3 R5 R10 rand8", n == 75, $urandom_range(0, 3) != 0, $urandom_range(0, 1), 0,
           rnd128(), rnd128(), $urandom_range(0, 25), $urandom_range(0, 15));
    step("R7 tail", 0, 0, 0, 0, '0, '0, 0, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  int int_sh[1];
endmodule